// File: doc/BRIEF.md
# Run-Length Sample Packet Encoder

This block turns a stream of 16-bit channel samples into run-length records ready for storage. Consecutive equal samples are merged into one record that holds the value and how many times it repeated. Records leave the block as a byte stream with a valid/ready handshake. Every five records are closed by a sequence byte, so storage always receives whole 16-byte packets.

A trigger marker travels with the sample stream. The first marked sample ends the open run, so the trigger always sits on a record boundary. The block reports how many records were completed before that point, which lets a reader find the trigger inside stored data. A flush ends a capture: the open run is emitted and a partial packet is padded with filler records. A small record buffer between the run builder and the byte serializer absorbs short stalls on the output.

Top module: `rle_packer`

## Requirements
- R1: After reset `byte_valid_o` is low and both `recs_pre_o` and `recs_total_o` are 0.
- R2: Each record is three bytes on `byte_o`: value bits 7:0, then value bits 15:8, then the repeat count. A data record's count equals the number of consecutive equal valid samples it covers and lies in 1..255.
- R3: A run that reaches 255 samples is closed, and the next equal sample starts a new record with count 1.
- R4: After every fifth record one sequence byte follows. It is 0 for the first packet after reset, rises by one per packet and wraps from 255 to 0.
- R5: The first valid sample that has `trig_i` high closes the open run and starts a new record, even if its value is unchanged. `recs_pre_o` counts the data records whose runs started before that sample. `trig_i` without `smp_valid_i`, and every later `trig_i`, have no effect.
- R6: A flush (`flush_i` high, `smp_valid_i` low) emits the open run. A partial packet is then padded with filler records (value 0, count 0) up to five records, followed by its sequence byte. A flush with no open run and no partial packet produces no bytes.
- R7: `recs_total_o` counts transmitted records, data and filler. Once the bytes of a flush have drained it is a multiple of five.
- R8: While `byte_valid_o` is high and `byte_ready_i` is low, `byte_o` and `byte_valid_o` hold their values. The byte stream is the same under any ready pattern, as long as no more than `FIFO_DEPTH` records are waiting. The record buffer is never written while it is full.
- R9: When the block is idle and its buffer is empty, a record closed by the sample taken at clock edge E shows its first byte with `byte_valid_o` high after edge E+1. It is not valid after edge E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | 16 | Sample value |
| smp_valid_i | input | 1 | Sample strobe |
| trig_i | input | 1 | Trigger marker, qualified by `smp_valid_i` |
| flush_i | input | 1 | End of capture; taken only when `smp_valid_i` is low |
| byte_o | output | 8 | Output byte |
| byte_valid_o | output | 1 | Output byte valid |
| byte_ready_i | input | 1 | Downstream ready |
| recs_pre_o | output | CNT_W | Data records completed before the trigger |
| recs_total_o | output | CNT_W | Records transmitted, filler included |

## Verification
The pre-trigger counter moves at the same edge that takes the closing sample. The first byte of a record on an idle block is due one edge later still: the buffer write takes one edge and the serializer pop takes the next. The bench checks this two-edge delay by reading `byte_valid_o` at the falling edge after each of the two rising edges. Byte contents and the counters are compared only after a drain loop has collected the whole stream expected by the bench's own model, plus a quiet margin, so no result depends on how long backpressure delayed it. Ready is driven and outputs are sampled at the falling edge, where every handshake is settled.

// File: rtl/rle_pkg.sv
package rle_pkg;
  localparam int SMP_W = 16;
  localparam int RUN_W = 8;

  typedef struct packed {
    logic             last;  // pad the packet after this entry
    logic             mark;  // flush marker, carries no record
    logic [SMP_W-1:0] val;
    logic [RUN_W-1:0] cnt;
  } rle_ent_t;
endpackage

// File: rtl/rle_run.sv
module rle_run
  import rle_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             smp_valid_i,
  input  logic             trig_i,
  input  logic             flush_i,
  output logic             push_o,
  output rle_ent_t         ent_o,
  output logic [CNT_W-1:0] recs_pre_o
);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic             active_q, pre_q, trig_seen_q;
  logic [SMP_W-1:0] val_q;
  logic [RUN_W-1:0] cnt_q;
  logic [CNT_W-1:0] pre_cnt_q;
  logic             trig_hit, brk, fl, start;

  assign trig_hit = smp_valid_i & trig_i & ~trig_seen_q;
  assign brk      = smp_valid_i & active_q &
                    ((smp_i != val_q) | (cnt_q == RUN_MAX) | trig_hit);
  assign fl       = flush_i & ~smp_valid_i;
  assign start    = smp_valid_i & (~active_q | brk);
  assign push_o   = brk | fl;

  always_comb begin
    ent_o      = '0;
    ent_o.last = fl;
    ent_o.mark = fl & ~active_q;
    if (active_q) begin
      ent_o.val = val_q;
      ent_o.cnt = cnt_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      pre_q       <= 1'b0;
      trig_seen_q <= 1'b0;
      val_q       <= '0;
      cnt_q       <= '0;
      pre_cnt_q   <= '0;
    end else begin
      if (push_o && active_q && pre_q) pre_cnt_q <= pre_cnt_q + 1'b1;
      if (trig_hit) trig_seen_q <= 1'b1;
      if (start) begin
        active_q <= 1'b1;
        val_q    <= smp_i;
        cnt_q    <= RUN_W'(1);
        pre_q    <= ~(trig_seen_q | trig_hit);
      end else if (smp_valid_i) begin
        cnt_q <= cnt_q + 1'b1;
      end else if (fl) begin
        active_q <= 1'b0;
      end
    end
  end

  assign recs_pre_o = pre_cnt_q;
endmodule

// File: rtl/rle_fifo.sv
module rle_fifo #(
  parameter int W     = 26,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, rp_q;

  assign empty_o = (wp_q == rp_q);
  assign full_o  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign dout_o  = mem[rp_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem[wp_q[AW-1:0]] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push_i && !full_o) wp_q <= wp_q + 1'b1;
      if (pop_i && !empty_o) rp_q <= rp_q + 1'b1;
    end
  end
endmodule

// File: rtl/rle_ser.sv
module rle_ser
  import rle_pkg::*;
#(
  parameter int REC_PER_PKT = 5,
  parameter int CNT_W       = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  rle_ent_t         head_i,
  input  logic             empty_i,
  output logic             pop_o,
  output logic [7:0]       byte_o,
  output logic             byte_valid_o,
  input  logic             byte_ready_i,
  output logic [CNT_W-1:0] recs_total_o
);
  localparam int SLOT_W = $clog2(REC_PER_PKT);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(REC_PER_PKT - 1);

  typedef enum logic [1:0] {S_IDLE, S_REC, S_SEQ} st_e;

  st_e              st_q;
  logic [1:0]       bidx_q;
  logic [SLOT_W-1:0] slot_q;
  logic [7:0]       seq_q;
  logic [SMP_W-1:0] val_q;
  logic [RUN_W-1:0] cnt_q;
  logic             pad_q;
  logic [CNT_W-1:0] total_q;
  logic             fire;

  assign pop_o        = (st_q == S_IDLE) & ~empty_i;
  assign byte_valid_o = (st_q != S_IDLE);
  assign fire         = byte_valid_o & byte_ready_i;

  always_comb begin
    byte_o = seq_q;
    if (st_q == S_REC) begin
      case (bidx_q)
        2'd0:    byte_o = val_q[7:0];
        2'd1:    byte_o = val_q[15:8];
        default: byte_o = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      bidx_q  <= '0;
      slot_q  <= '0;
      seq_q   <= '0;
      val_q   <= '0;
      cnt_q   <= '0;
      pad_q   <= 1'b0;
      total_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (pop_o) begin
          bidx_q <= '0;
          if (head_i.mark) begin
            // marker alone: pad only if a packet is partly sent
            if (slot_q != '0) begin
              val_q <= '0;
              cnt_q <= '0;
              pad_q <= 1'b1;
              st_q  <= S_REC;
            end
          end else begin
            val_q <= head_i.val;
            cnt_q <= head_i.cnt;
            pad_q <= head_i.last;
            st_q  <= S_REC;
          end
        end
        S_REC: if (fire) begin
          if (bidx_q == 2'd2) begin
            bidx_q  <= '0;
            total_q <= total_q + 1'b1;
            if (slot_q == LAST_SLOT) begin
              slot_q <= '0;
              st_q   <= S_SEQ;
            end else begin
              slot_q <= slot_q + 1'b1;
              if (pad_q) begin
                val_q <= '0;
                cnt_q <= '0;
              end else begin
                st_q <= S_IDLE;
              end
            end
          end else begin
            bidx_q <= bidx_q + 1'b1;
          end
        end
        S_SEQ: if (fire) begin
          seq_q <= seq_q + 1'b1;
          pad_q <= 1'b0;
          st_q  <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign recs_total_o = total_q;
endmodule

// File: rtl/rle_packer.sv
module rle_packer
  import rle_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int FIFO_DEPTH  = 8,
  parameter int REC_PER_PKT = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [15:0]      smp_i,
  input  logic             smp_valid_i,
  input  logic             trig_i,
  input  logic             flush_i,
  output logic [7:0]       byte_o,
  output logic             byte_valid_o,
  input  logic             byte_ready_i,
  output logic [CNT_W-1:0] recs_pre_o,
  output logic [CNT_W-1:0] recs_total_o
);
  localparam int ENT_W = $bits(rle_ent_t);

  rle_ent_t   push_ent, head_ent;
  logic       rec_push, fifo_pop, fifo_full, fifo_empty;
  logic [ENT_W-1:0] head_raw;

  rle_run #(.CNT_W(CNT_W)) u_run (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .smp_i       (smp_i),
    .smp_valid_i (smp_valid_i),
    .trig_i      (trig_i),
    .flush_i     (flush_i),
    .push_o      (rec_push),
    .ent_o       (push_ent),
    .recs_pre_o  (recs_pre_o)
  );

  rle_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rec_push),
    .din_i   (push_ent),
    .pop_i   (fifo_pop),
    .dout_o  (head_raw),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  assign head_ent = rle_ent_t'(head_raw);

  rle_ser #(.REC_PER_PKT(REC_PER_PKT), .CNT_W(CNT_W)) u_ser (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .head_i       (head_ent),
    .empty_i      (fifo_empty),
    .pop_o        (fifo_pop),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o),
    .byte_ready_i (byte_ready_i),
    .recs_total_o (recs_total_o)
  );
endmodule

// File: rtl/rle_packer_chk.sv
module rle_packer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       byte_o,
  input logic             byte_valid_o,
  input logic             byte_ready_i,
  input logic             push_i,
  input logic             push_mark_i,
  input logic [7:0]       push_cnt_i,
  input logic             full_i,
  input logic [CNT_W-1:0] recs_pre_o
);
  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_i);

  assert_hold_byte_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && !byte_ready_i) |=> (byte_valid_o && $stable(byte_o)));

  assert_count_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !push_mark_i) |-> (push_cnt_i != 8'd0));

  assert_pre_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recs_pre_o != $past(recs_pre_o)) |-> (recs_pre_o == $past(recs_pre_o) + 1'b1));
endmodule

bind rle_packer rle_packer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_o       (byte_o),
  .byte_valid_o (byte_valid_o),
  .byte_ready_i (byte_ready_i),
  .push_i       (rec_push),
  .push_mark_i  (push_ent.mark),
  .push_cnt_i   (push_ent.cnt),
  .full_i       (fifo_full),
  .recs_pre_o   (recs_pre_o)
);

// File: tb/rle_packer_test.sv
`timescale 1ns/1ps
module rle_packer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] smp_i = '0;
  logic        smp_valid_i = 1'b0, trig_i = 1'b0, flush_i = 1'b0;
  logic        byte_ready_i = 1'b1;
  logic [7:0]  byte_o;
  logic        byte_valid_o;
  logic [31:0] recs_pre_o, recs_total_o;

  always #2.5 clk_i = ~clk_i;

  rle_packer uut (
    .clk_i, .rst_ni, .smp_i, .smp_valid_i, .trig_i, .flush_i,
    .byte_o, .byte_valid_o, .byte_ready_i, .recs_pre_o, .recs_total_o
  );

  int n_chk = 0, n_fail = 0;
  int bp_mode = 0;
  int cyc = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] cap_q[$];
  logic [7:0] exp_q[$];

  // reference model state
  bit m_active, m_run_pre, m_trig;
  logic [15:0] m_val;
  int m_cnt, m_pre, m_slot, m_seq, m_total;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ready driven and bytes captured at the falling edge
  always @(negedge clk_i) begin
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (bp_mode)
      1:       byte_ready_i = lfsr[0];
      2:       byte_ready_i = ((cyc % 60) >= 40);
      default: byte_ready_i = 1'b1;
    endcase
    if (rst_ni && byte_valid_o && byte_ready_i) cap_q.push_back(byte_o);
  end

  function automatic void emit_rec(input logic [15:0] v, input int c);
    exp_q.push_back(v[7:0]);
    exp_q.push_back(v[15:8]);
    exp_q.push_back(8'(c));
    m_total++;
    m_slot++;
    if (m_slot == 5) begin
      exp_q.push_back(8'(m_seq));
      m_seq = (m_seq + 1) % 256;
      m_slot = 0;
    end
  endfunction

  function automatic void model_smp(input logic [15:0] v, input bit t);
    bit th;
    th = t && !m_trig;
    if (m_active && (v != m_val || m_cnt == 255 || th)) begin
      if (m_run_pre) m_pre++;
      emit_rec(m_val, m_cnt);
      m_active = 0;
    end
    if (!m_active) begin
      m_active = 1; m_val = v; m_cnt = 1; m_run_pre = !(m_trig || th);
    end else m_cnt++;
    if (th) m_trig = 1;
  endfunction

  function automatic void model_flush();
    if (m_active) begin
      if (m_run_pre) m_pre++;
      emit_rec(m_val, m_cnt);
      m_active = 0;
    end
    while (m_slot != 0) emit_rec(16'h0, 0);
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; smp_valid_i = 0; trig_i = 0; flush_i = 0; bp_mode = 0;
    m_active = 0; m_run_pre = 0; m_trig = 0; m_val = '0;
    m_cnt = 0; m_pre = 0; m_slot = 0; m_seq = 0; m_total = 0;
    exp_q.delete();
    repeat (3) @(negedge clk_i);
    cap_q.delete();
    rst_ni = 1'b1;
  endtask

  task automatic smp(input logic [15:0] v, input bit t);
    @(negedge clk_i);
    smp_i = v; smp_valid_i = 1'b1; trig_i = t;
    model_smp(v, t);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      smp_valid_i = 1'b0; trig_i = 1'b0; flush_i = 1'b0;
    end
  endtask

  task automatic flush();
    @(negedge clk_i);
    smp_valid_i = 1'b0; trig_i = 1'b0; flush_i = 1'b1;
    model_flush();
    @(negedge clk_i);
    flush_i = 1'b0;
  endtask

  task automatic drain(input string req);
    int first_bad;
    for (int i = 0; i < 40000 && cap_q.size() < exp_q.size(); i++) @(negedge clk_i);
    repeat (30) @(negedge clk_i);
    chk(cap_q.size() == exp_q.size(), {req, " byte count"}, cap_q.size(), exp_q.size());
    first_bad = -1;
    for (int i = 0; i < exp_q.size() && i < cap_q.size(); i++)
      if (first_bad < 0 && cap_q[i] != exp_q[i]) first_bad = i;
    if (first_bad >= 0)
      chk(0, {req, " byte content"}, cap_q[first_bad], exp_q[first_bad]);
    else
      chk(1, req, 0, 0);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk_i);
    chk(byte_valid_o == 1'b0, "R1 valid", byte_valid_o, 0);
    chk(recs_pre_o == 0, "R1 pre count", recs_pre_o, 0);
    chk(recs_total_o == 0, "R1 total count", recs_total_o, 0);
  endtask

  task automatic t_latency();
    do_reset();
    smp(16'hC3A5, 0);
    smp(16'h0001, 0);  // sampled at edge E, closes 0xC3A5
    @(negedge clk_i);
    smp_valid_i = 1'b0;
    chk(byte_valid_o == 1'b0, "R9 not yet valid after E", byte_valid_o, 0);
    @(negedge clk_i);
    chk(byte_valid_o == 1'b1, "R9 valid after E+1", byte_valid_o, 1);
    chk(byte_o == 8'hA5, "R9 first byte", byte_o, 8'hA5);
    flush();
    drain("R2 latency stream");
  endtask

  task automatic t_runs();
    do_reset();
    repeat (5) smp(16'h1234, 0);
    smp(16'hABCD, 0);
    repeat (300) smp(16'h00FF, 0);  // R3: 255 + 45
    repeat (3) smp(16'h8001, 0);
    repeat (510) smp(16'h5A5A, 0);  // R3: exactly two full runs
    repeat (2) smp(16'h5A5A, 0);
    idle(2);
    flush();
    drain("R2 R3 run records");
    chk(recs_total_o == m_total, "R7 total records", recs_total_o, m_total);
    chk(recs_total_o % 5 == 0, "R7 multiple of five", recs_total_o % 5, 0);
  endtask

  task automatic t_trigger();
    do_reset();
    smp(16'h0011, 0); smp(16'h0011, 0);
    smp(16'h0022, 0);
    smp(16'h0033, 0); smp(16'h0033, 0);
    smp(16'h0033, 1);                   // R5 closes run of equal value
    smp(16'h0033, 0);
    @(negedge clk_i); smp_valid_i = 0; trig_i = 1;  // R5 ignored, no sample
    smp(16'h0033, 0);
    smp(16'h0033, 1);                   // R5 second trigger ignored
    smp(16'h0044, 0);
    idle(3);
    chk(recs_pre_o == 3, "R5 pre-trigger records", recs_pre_o, 3);
    flush();
    drain("R5 trigger stream");
    chk(recs_pre_o == m_pre, "R5 pre count after flush", recs_pre_o, m_pre);
  endtask

  task automatic t_flush();
    do_reset();
    flush();
    idle(20);
    chk(cap_q.size() == 0, "R6 empty flush no bytes", cap_q.size(), 0);
    for (int i = 0; i < 5; i++) smp(16'(16'h0100 + i), 0);
    idle(1);
    flush();                           // closes fifth record, no filler
    drain("R6 full packet flush");
    smp(16'hBEEF, 0);
    idle(1);
    flush();                           // one record plus four fillers
    drain("R6 padded flush");
    chk(recs_total_o == 10, "R7 total after pads", recs_total_o, 10);
  endtask

  task automatic t_backpressure(input int mode);
    do_reset();
    bp_mode = mode;
    for (int i = 0; i < 40; i++) begin
      smp(16'(16'h7000 + (i % 3)), 0);
      smp(16'(16'h7000 + (i % 3)), 0);
      idle(14);
    end
    flush();
    drain(mode == 1 ? "R8 random ready" : "R8 long stall");
    chk(recs_total_o == m_total, "R8 total under stall", recs_total_o, m_total);
  endtask

  task automatic t_seq_wrap();
    do_reset();
    for (int i = 0; i < 1310; i++) begin
      smp(16'(i), 0);
      idle(4);
    end
    flush();
    drain("R4 sequence wrap");
    chk(m_seq < 10 && recs_total_o > 1280, "R4 wrapped past 255",
        recs_total_o, m_total);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_runs();
    t_trigger();
    t_flush();
    t_backpressure(1);
    t_backpressure(2);
    t_seq_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule